// File: doc/BRIEF.md
# Two-Lane Source-Routed Router Input Port

This block is one input port of a five-direction wormhole router in a 2-D mesh. Flits of 34 bits arrive on a shared link. A per-lane request line says which of two virtual-channel lanes the flit belongs to, and the port answers on a matching per-lane response line. Each lane holds exactly one flit. When a packet head is loaded, the port decodes the output direction from the low two bits of the head's route field. It then shifts that field right by two bits so that the next router finds its own hop in the low bits.

Each lane remembers the direction of the packet it is carrying for the whole packet (the wormhole lock). The lane offers its buffered flit, the direction, a send flag and the lock flag to the output side. The output side pops the flit with a per-lane acknowledge. Flit bit 33 marks begin-of-packet and bit 32 marks end-of-packet. The route field is bits 17:0 of a head flit. Direction codes are 0 North, 1 East, 2 South, 3 West and 4 Local.

Each lane runs a three-state machine:
- LANE_IDLE: no packet and no flit.
- LANE_FULL: flit held and packet locked.
- LANE_GAP: packet locked and buffer empty.

The transitions are:
- IDLE to FULL on an accepted head.
- FULL to IDLE when a tail leaves and no new head arrives.
- FULL to FULL when the flit leaves and a new flit enters in the same cycle, or while nothing leaves.
- FULL to GAP when a non-tail leaves and nothing enters.
- GAP to FULL on any accepted flit.

Top module: `noc_src_route_inport`

## Requirements
- R1: A flit presented with in_req[0] goes to lane 0, and one presented with in_req[1] goes to lane 1. A flit is accepted only in a cycle where the request and the matching in_resp bit are both high.
- R2: An accepted head flit (bit 33 = 1) with a nonzero route field bits 17:0 sets the lane direction to the route's bits 1:0 (0 North, 1 East, 2 South, 3 West).
- R3: A head whose route field bits 17:0 are all zero sets the lane direction to 4 (Local).
- R4: The buffered copy of a head has bits 17:0 replaced by the route field shifted right by two. Bits 33:18 are unchanged, and body and tail flits are buffered unchanged.
- R5: While a lane is locked, its direction stays that of the packet's head, and lane_lock stays high across body flits and across empty-buffer gaps.
- R6: When a flit with bit 32 = 1 leaves a lane on an acknowledge, and no new head enters that lane in the same cycle, lane_lock is low on the next cycle.
- R7: in_resp for a lane is high only when that lane's buffer is empty or is acknowledged in the same cycle (combinational).
- R8: If in_req[0] and in_req[1] are both high, only lane 0 may accept, and in_resp[1] is low.
- R9: A single-flit packet (bits 33 and 32 both 1) locks its lane and releases it when it is acknowledged.
- R10: A flit accepted at a clock edge appears as lane_send and lane_flit right after that edge.
- R11: A non-head flit that reaches an unlocked lane is accepted and discarded: lane_send and lane_lock stay low.
- R12: After reset, every lane is unlocked and empty, and in_resp is high for both lanes.
- R13: An acknowledge to a lane with no buffered flit has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_flit | input | 34 | Incoming flit from the link |
| in_req | input | 2 | Per-lane request, bit v selects lane v |
| in_resp | output | 2 | Per-lane acceptance, combinational |
| lane_flit | output | 68 | Buffered flit of lane v at bits v*34 +: 34 |
| lane_dir | output | 6 | Locked direction of lane v at bits v*3 +: 3 |
| lane_send | output | 2 | Lane v holds a flit for the output side |
| lane_lock | output | 2 | Lane v carries an open packet |
| lane_ack | input | 2 | Output side takes the flit of lane v |

## Verification
in_resp depends combinationally on the same-cycle requests and acknowledges. The bench drives inputs at the falling edge and compares in_resp one time step later, before the next rising edge. The flit, direction, send and lock outputs change at the rising edge that accepts or drains a flit. They are compared at the following falling edge against a behavioural model that updates at that rising edge. Every cycle is compared this way, both in the directed scenarios and in a long stretch of mixed traffic that includes head reloads in the same cycle as a drain and double requests.

// File: rtl/noc_inport_pkg.sv
package noc_inport_pkg;

    parameter int FLIT_W  = 34;
    parameter int ROUTE_W = 18;
    parameter int HOP_W   = 2;
    parameter int NUM_VC  = 2;

    typedef enum logic [1:0] {
        LANE_IDLE = 2'd0,
        LANE_FULL = 2'd1,
        LANE_GAP  = 2'd2
    } lane_state_e;

endpackage

// File: rtl/noc_hop_decode.sv
module noc_hop_decode #(
    parameter int FLIT_W  = 34,
    parameter int ROUTE_W = 18,
    parameter int HOP_W   = 2,
    parameter int DIR_W   = HOP_W + 1
) (
    input  logic [FLIT_W-1:0] raw_flit,
    output logic [DIR_W-1:0]  hop_dir,
    output logic [FLIT_W-1:0] fwd_flit
);
    localparam logic [DIR_W-1:0] LOCAL_CODE = DIR_W'(1 << HOP_W);

    logic [ROUTE_W-1:0] route;

    always_comb begin
        route = raw_flit[ROUTE_W-1:0];
        if (route == '0) begin
            hop_dir = LOCAL_CODE;
        end else begin
            hop_dir = DIR_W'(route[HOP_W-1:0]);
        end
        fwd_flit                = raw_flit;
        fwd_flit[ROUTE_W-1:0]   = route >> HOP_W;
    end
endmodule

// File: rtl/noc_vc_steer.sv
module noc_vc_steer #(
    parameter int NUM_VC = 2
) (
    input  logic [NUM_VC-1:0] req,
    input  logic [NUM_VC-1:0] ready,
    output logic [NUM_VC-1:0] resp,
    output logic [NUM_VC-1:0] take
);
    logic [NUM_VC-1:0] blocked;

    for (genvar v = 0; v < NUM_VC; v++) begin : g_lane
        if (v == 0) begin : g_top
            assign blocked[v] = 1'b0;
        end else begin : g_low
            assign blocked[v] = |req[v-1:0];
        end
        assign resp[v] = ready[v] & ~blocked[v];
        assign take[v] = req[v] & resp[v];
    end
endmodule

// File: rtl/noc_vc_lane.sv
module noc_vc_lane
    import noc_inport_pkg::*;
#(
    parameter int FLIT_W  = 34,
    parameter int DIR_W   = 3,
    parameter int BOP_BIT = FLIT_W - 1,
    parameter int EOP_BIT = FLIT_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [FLIT_W-1:0] raw_flit,
    input  logic [FLIT_W-1:0] hdr_flit,
    input  logic [DIR_W-1:0]  hdr_dir,
    input  logic              ack,
    output logic              ready,
    output logic              send,
    output logic              lock,
    output logic [FLIT_W-1:0] buf_flit,
    output logic [DIR_W-1:0]  buf_dir
);
    lane_state_e state_q, state_d;
    logic        load_hdr, load_raw;
    logic        head_in;

    assign head_in = take & raw_flit[BOP_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LANE_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        load_hdr = 1'b0;
        load_raw = 1'b0;
        unique case (state_q)
            LANE_IDLE: begin
                if (head_in) begin
                    load_hdr = 1'b1;
                    state_d  = LANE_FULL;
                end
            end
            LANE_FULL: begin
                if (ack) begin
                    if (buf_flit[EOP_BIT]) begin
                        if (head_in) begin
                            load_hdr = 1'b1;
                        end else begin
                            state_d = LANE_IDLE;
                        end
                    end else if (take) begin
                        load_raw = 1'b1;
                    end else begin
                        state_d = LANE_GAP;
                    end
                end
            end
            LANE_GAP: begin
                if (take) begin
                    load_raw = 1'b1;
                    state_d  = LANE_FULL;
                end
            end
            default: state_d = LANE_IDLE;
        endcase
    end

    always_comb begin
        send  = (state_q == LANE_FULL);
        lock  = (state_q != LANE_IDLE);
        ready = (state_q != LANE_FULL) | ack;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_flit <= '0;
            buf_dir  <= '0;
        end else if (load_hdr) begin
            buf_flit <= hdr_flit;
            buf_dir  <= hdr_dir;
        end else if (load_raw) begin
            buf_flit <= raw_flit;
        end
    end

    // R5
    dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock && $past(lock) && !$past(load_hdr)) |-> (buf_dir == $past(buf_dir)));

    // R6
    lock_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (send && ack && buf_flit[EOP_BIT] && !head_in) |=> !lock);

    // R10
    hdr_send_chk: assert property (@(posedge clk) disable iff (!rst_n)
        head_in |=> send);

    // R11
    orphan_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!lock && take && !raw_flit[BOP_BIT]) |=> !send);
endmodule

// File: rtl/noc_src_route_inport.sv
module noc_src_route_inport
    import noc_inport_pkg::*;
#(
    parameter int NUM_VC_P  = NUM_VC,
    parameter int FLIT_W_P  = FLIT_W,
    parameter int ROUTE_W_P = ROUTE_W,
    parameter int HOP_W_P   = HOP_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [FLIT_W_P-1:0]          in_flit,
    input  logic [NUM_VC_P-1:0]          in_req,
    output logic [NUM_VC_P-1:0]          in_resp,
    output logic [NUM_VC_P*FLIT_W_P-1:0] lane_flit,
    output logic [NUM_VC_P*(HOP_W_P+1)-1:0] lane_dir,
    output logic [NUM_VC_P-1:0]          lane_send,
    output logic [NUM_VC_P-1:0]          lane_lock,
    input  logic [NUM_VC_P-1:0]          lane_ack
);
    localparam int DIR_W   = HOP_W_P + 1;
    localparam int BOP_BIT = FLIT_W_P - 1;
    localparam int EOP_BIT = FLIT_W_P - 2;

    logic [DIR_W-1:0]    hdr_dir;
    logic [FLIT_W_P-1:0] hdr_flit;
    logic [NUM_VC_P-1:0] ready, take;

    noc_hop_decode #(
        .FLIT_W (FLIT_W_P),
        .ROUTE_W(ROUTE_W_P),
        .HOP_W  (HOP_W_P),
        .DIR_W  (DIR_W)
    ) u_decode (
        .raw_flit(in_flit),
        .hop_dir (hdr_dir),
        .fwd_flit(hdr_flit)
    );

    noc_vc_steer #(.NUM_VC(NUM_VC_P)) u_steer (
        .req  (in_req),
        .ready(ready),
        .resp (in_resp),
        .take (take)
    );

    for (genvar v = 0; v < NUM_VC_P; v++) begin : g_vc
        noc_vc_lane #(
            .FLIT_W (FLIT_W_P),
            .DIR_W  (DIR_W),
            .BOP_BIT(BOP_BIT),
            .EOP_BIT(EOP_BIT)
        ) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .take    (take[v]),
            .raw_flit(in_flit),
            .hdr_flit(hdr_flit),
            .hdr_dir (hdr_dir),
            .ack     (lane_ack[v]),
            .ready   (ready[v]),
            .send    (lane_send[v]),
            .lock    (lane_lock[v]),
            .buf_flit(lane_flit[v*FLIT_W_P +: FLIT_W_P]),
            .buf_dir (lane_dir[v*DIR_W +: DIR_W])
        );

        // R7
        take_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
            take[v] |-> (!lane_send[v] || lane_ack[v]));
    end

    // R8
    one_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(take));
endmodule

// File: tb/noc_src_route_inport_tb.sv
`timescale 1ns/1ps
module noc_src_route_inport_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [33:0] in_flit;
    logic [1:0]  in_req;
    logic [1:0]  in_resp;
    logic [67:0] lane_flit;
    logic [5:0]  lane_dir;
    logic [1:0]  lane_send;
    logic [1:0]  lane_lock;
    logic [1:0]  lane_ack;

    always #4 clk = ~clk;

    noc_src_route_inport u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_flit  (in_flit),
        .in_req   (in_req),
        .in_resp  (in_resp),
        .lane_flit(lane_flit),
        .lane_dir (lane_dir),
        .lane_send(lane_send),
        .lane_lock(lane_lock),
        .lane_ack (lane_ack)
    );

    int    checks = 0;
    int    errors = 0;
    bit    done   = 1'b0;
    string scen   = "R12";

    bit          mfull [2];
    bit          mlock [2];
    int          mdir  [2];
    logic [33:0] mbuf  [2];

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s (%s) at %0t: actual %0h expected %0h", tag, scen, $time, act, exp);
        end
    endtask

    function automatic logic [33:0] mk(input bit b, input bit e, input logic [31:0] p);
        return {b, e, p};
    endfunction

    task automatic step(input logic [1:0] rq, input logic [33:0] f, input logic [1:0] ak);
        bit rsp [2];
        in_req   = rq;
        in_flit  = f;
        lane_ack = ak;
        #1;
        rsp[0] = !mfull[0] || ak[0];
        rsp[1] = (!mfull[1] || ak[1]) && !rq[0];
        for (int v = 0; v < 2; v++) begin
            chk(in_resp[v] == rsp[v], (v == 1 && rq[0]) ? "R8" : "R7", 64'(in_resp[v]), 64'(rsp[v]));
            chk(lane_send[v] == mfull[v], "R10", 64'(lane_send[v]), 64'(mfull[v]));
            chk(lane_lock[v] == mlock[v], "R6", 64'(lane_lock[v]), 64'(mlock[v]));
            if (mfull[v])
                chk(lane_flit[v*34 +: 34] == mbuf[v], "R4", 64'(lane_flit[v*34 +: 34]), 64'(mbuf[v]));
            if (mlock[v])
                chk(int'(lane_dir[v*3 +: 3]) == mdir[v], (mdir[v] == 4) ? "R3" : "R2",
                    64'(lane_dir[v*3 +: 3]), 64'(mdir[v]));
        end
        @(posedge clk);
        for (int v = 0; v < 2; v++) begin
            bit acc;
            acc = rq[v] && rsp[v];
            if (mfull[v] && ak[v]) begin
                if (mbuf[v][32]) mlock[v] = 1'b0;
                mfull[v] = 1'b0;
            end
            if (acc) begin
                if (!mlock[v]) begin
                    if (f[33]) begin
                        logic [17:0] rt;
                        rt       = f[17:0];
                        mlock[v] = 1'b1;
                        mdir[v]  = (rt == 0) ? 4 : int'(rt % 4);
                        mbuf[v]  = {f[33:18], rt >> 2};
                        mfull[v] = 1'b1;
                    end
                end else begin
                    mbuf[v]  = f;
                    mfull[v] = 1'b1;
                end
            end
        end
        @(negedge clk);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; in_req = 2'b00; in_flit = '0; lane_ack = 2'b00;
        for (int v = 0; v < 2; v++) begin
            mfull[v] = 0; mlock[v] = 0; mdir[v] = 0; mbuf[v] = '0;
        end
        repeat (3) @(negedge clk);
        // R12: reset state at the ports
        chk(lane_send == 2'b00, "R12", 64'(lane_send), 64'd0);
        chk(lane_lock == 2'b00, "R12", 64'(lane_lock), 64'd0);
        chk(in_resp == 2'b11, "R12", 64'(in_resp), 64'd3);
        rst_n = 1'b1;
        @(negedge clk);

        scen = "R2";   // head East on lane 0, held without ack
        step(2'b01, mk(1, 0, 32'h0000_1D01), 2'b00);
        scen = "R7";   // lane 0 full, no ack: resp low
        step(2'b01, mk(0, 0, 32'hAAAA_0001), 2'b00);
        scen = "R5";   // drain head, body arrives in same cycle
        step(2'b01, mk(0, 0, 32'hAAAA_0001), 2'b01);
        step(2'b00, '0, 2'b01);      // drain body, gap
        step(2'b00, '0, 2'b00);
        step(2'b01, mk(0, 0, 32'hBBBB_0002), 2'b00);
        scen = "R6";
        step(2'b01, mk(0, 1, 32'hCCCC_0003), 2'b01);
        step(2'b00, '0, 2'b01);
        step(2'b00, '0, 2'b00);
        scen = "R3";   // zero route goes Local
        step(2'b01, mk(1, 0, 32'h1234_0000), 2'b00);
        step(2'b00, '0, 2'b01);
        step(2'b01, mk(0, 1, 32'h0000_00FF), 2'b00);
        step(2'b00, '0, 2'b01);
        scen = "R9";   // single-flit packet, South, on lane 1
        step(2'b10, mk(1, 1, 32'h0000_0006), 2'b00);
        step(2'b00, '0, 2'b10);
        step(2'b00, '0, 2'b00);
        scen = "R8";   // both requests: lane 0 only
        step(2'b11, mk(1, 0, 32'h0000_0003), 2'b00);
        step(2'b11, mk(0, 1, 32'h0000_0007), 2'b01);
        step(2'b00, '0, 2'b01);
        scen = "R11";  // orphan body on unlocked lane 1
        step(2'b10, mk(0, 0, 32'hDEAD_BEEF), 2'b00);
        step(2'b00, '0, 2'b00);
        scen = "R13";  // ack to empty lanes
        step(2'b00, '0, 2'b11);
        step(2'b00, '0, 2'b00);
        scen = "R1";   // tail drains while next head enters, lane 1
        step(2'b10, mk(1, 1, 32'h0000_0005), 2'b00);
        step(2'b10, mk(1, 0, 32'h0000_000B), 2'b10);
        step(2'b10, mk(0, 1, 32'h0000_0000), 2'b10);
        step(2'b00, '0, 2'b10);
        step(2'b00, '0, 2'b00);

        scen = "R1";   // mixed traffic
        for (int i = 0; i < 4000; i++) begin
            logic [1:0]  rq;
            logic [1:0]  ak;
            logic [31:0] p;
            int unsigned r;
            r  = $urandom % 8;
            rq = (r < 4) ? 2'b00 : (r < 6) ? 2'b01 : (r == 6) ? 2'b10 : 2'b11;
            p  = $urandom;
            if ($urandom % 5 == 0) p[17:0] = '0;
            ak = 2'($urandom);
            step(rq, mk(($urandom % 3) == 0, ($urandom % 3) == 0, p), ak);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule